// File: doc/BRIEF.md
# Mixed Page Size Translation Cache

This block keeps a small, fully associative set of finished address translations between the requests of a device and the page table walker. Each entry holds a virtual tag, a physical base and a page size code. The code selects one of three page sizes: 4 KB, 64 KB or 1 MB. A request whose address falls inside exactly one valid entry's page is answered from the cache one cycle after it is accepted. A request that matches no entry is handed to the walker and held there until the walker answers. A good answer is returned to the requester and written into an entry. A fault answer is returned without writing anything.

Two kinds of invalidation are supported: one that clears the whole cache, and one that clears every entry whose page contains a given 4 KB page. If more than one valid entry covers a request, the block does not translate it. It reports a multi-hit fault instead, and the fault type records whether the request was a read or a write. On a refill, the victim is the lowest-numbered empty entry if one exists, otherwise the least recently used entry.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, `req_ready` is 1, and `rsp_valid` and `walk_req_valid` are 0.
- R2: When a request is accepted (`req_valid` and `req_ready` both high at a rising edge) and exactly one valid entry covers its address, `rsp_valid` is 1 for one cycle after that edge. In that cycle `rsp_fault` is 0 and `rsp_paddr` holds the entry's base above the page boundary and the request address below it. No walk is started.
- R3: An entry with size code 0 compares address bits [31:12], code 1 compares bits [31:16], and code 2 compares bits [31:20]. Code 3 is treated as code 0.
- R4: A request that no entry covers raises `walk_req_valid` one cycle after acceptance, with `walk_req_vaddr` equal to the request address. Both are held, and `req_ready` stays 0, until `walk_rsp_valid` is sampled high. One cycle after that sample, `rsp_valid` is 1 and `rsp_paddr` is built from the walker's base and size code, split at the page boundary as in R2.
- R5: A walker answer with `walk_rsp_fault` set gives `rsp_fault`=1, `rsp_fault_kind`=0 and `rsp_paddr`=0, and no entry is written. A later lookup of the same address misses again.
- R6: If two or more valid entries cover an accepted request, the response has `rsp_fault`=1, `rsp_paddr`=0 and `rsp_fault_kind` set to 1 for a read (`req_write`=0) or 2 for a write. No walk is started and recency is not changed.
- R7: `flush_all` makes every entry invalid at the next edge. `req_ready` is 0 in any cycle where a flush input is high.
- R8: `flush_page` invalidates each valid entry whose page contains the 4 KB page of `flush_addr`. Entries that do not contain that page are kept.
- R9: If a flush is high in the same cycle as a walker answer, the answer is still returned, but no entry is written and recency is not updated.
- R10: A refill goes to the lowest-numbered invalid entry. If every entry is valid, it goes to the least recently used entry. Single hits and refills both count as uses. Flushes leave the use order unchanged. After reset, entry 0 is the most recent and the last entry is the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for the write channel, 0 for the read channel |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Translated physical address (0 on a fault) |
| rsp_fault | output | 1 | Response carries a fault |
| rsp_fault_kind | output | 2 | 0 walker fault, 1 read multi-hit, 2 write multi-hit |
| walk_req_valid | output | 1 | Walk request pending |
| walk_req_vaddr | output | 32 | Address to be walked |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_pbase | input | 32 | Physical base from the walker |
| walk_rsp_size | input | 2 | Page size code from the walker |
| walk_rsp_fault | input | 1 | Walker found no translation |
| flush_all | input | 1 | Invalidate every entry |
| flush_page | input | 1 | Invalidate entries covering flush_addr |
| flush_addr | input | 32 | 4 KB page to invalidate |

## Verification
A hit or a multi-hit answer is due one cycle after the edge that accepts the request. A walk request is visible in that same cycle, and a walker-served answer arrives one cycle after the edge that samples `walk_rsp_valid`. The bench drives every input on the falling edge. It reads each result on the next falling edge after the edge that is responsible for it, so each check sits exactly one register stage behind its cause. While a walk is pending, the bench checks that the walk request and a low `req_ready` are still held on every falling edge before it answers.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int unsigned AW = 32;

  localparam logic [1:0] PG_4K  = 2'd0;
  localparam logic [1:0] PG_64K = 2'd1;
  localparam logic [1:0] PG_1M  = 2'd2;

  localparam logic [1:0] FK_WALK     = 2'd0;
  localparam logic [1:0] FK_MULTI_RD = 2'd1;
  localparam logic [1:0] FK_MULTI_WR = 2'd2;

  // Mask of the compared (page number) bits for a size code.
  function automatic logic [AW-1:0] page_mask(input logic [1:0] sz);
    case (sz)
      PG_1M:   page_mask = 32'hFFF0_0000;
      PG_64K:  page_mask = 32'hFFFF_0000;
      default: page_mask = 32'hFFFF_F000;
    endcase
  endfunction

  // True when the page starting at tag, of size sz, contains addr.
  function automatic logic covers(input logic [AW-1:0] tag, input logic [1:0] sz,
                                  input logic [AW-1:0] addr);
    covers = ((tag ^ addr) & page_mask(sz)) == '0;
  endfunction

  // Physical base above the page boundary, virtual offset below it.
  function automatic logic [AW-1:0] join_addr(input logic [AW-1:0] base,
                                              input logic [1:0] sz,
                                              input logic [AW-1:0] va);
    join_addr = (base & page_mask(sz)) | (va & ~page_mask(sz));
  endfunction
endpackage

// File: rtl/xc_match.sv
module xc_match #(
  parameter int unsigned ENTRIES = 8
) (
  input  logic [ENTRIES-1:0]                 valid,
  input  logic [ENTRIES-1:0][xc_pkg::AW-1:0] tags,
  input  logic [ENTRIES-1:0][1:0]            sizes,
  input  logic [xc_pkg::AW-1:0]              addr,
  output logic [ENTRIES-1:0]                 hits
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hits[i] = valid[i] && xc_pkg::covers(tags[i], sizes[i], addr);
  end
endmodule

// File: rtl/xc_lru.sv
module xc_lru #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDXW = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ENTRIES-1:0]  valid,
  input  logic                touch_en,
  input  logic [IDXW-1:0]     touch_idx,
  output logic [IDXW-1:0]     victim
);
  localparam logic [IDXW-1:0] OLDEST = IDXW'(ENTRIES - 1);

  // age 0 = most recent; ages always form a permutation of 0..ENTRIES-1
  logic [ENTRIES-1:0][IDXW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDXW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDXW'(i) == touch_idx)          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid[i] && !found) begin
        victim = IDXW'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < ENTRIES; i++)
        if (age_q[i] == OLDEST) victim = IDXW'(i);
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int unsigned ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic [1:0]  rsp_fault_kind,
  output logic        walk_req_valid,
  output logic [31:0] walk_req_vaddr,
  input  logic        walk_rsp_valid,
  input  logic [31:0] walk_rsp_pbase,
  input  logic [1:0]  walk_rsp_size,
  input  logic        walk_rsp_fault,
  input  logic        flush_all,
  input  logic        flush_page,
  input  logic [31:0] flush_addr
);
  import xc_pkg::*;
  localparam int unsigned IDXW = $clog2(ENTRIES);
  localparam int unsigned CNTW = $clog2(ENTRIES + 1);

  typedef enum logic {ST_IDLE, ST_WALK} state_t;
  state_t state_q;

  logic [ENTRIES-1:0]          valid_q;
  logic [ENTRIES-1:0][AW-1:0]  tag_q;
  logic [ENTRIES-1:0][AW-1:0]  base_q;
  logic [ENTRIES-1:0][1:0]     size_q;
  logic [AW-1:0]               va_q;
  logic                        wr_q;

  // Named internal events
  logic [ENTRIES-1:0] hit_vec, fhit_vec;
  logic [CNTW-1:0]    hit_cnt;
  logic [IDXW-1:0]    hit_idx, victim, touch_idx;
  logic               accept, walk_done, flush_any, refill_en, touch_en;

  xc_match #(.ENTRIES(ENTRIES)) u_look (
    .valid(valid_q), .tags(tag_q), .sizes(size_q), .addr(req_vaddr), .hits(hit_vec)
  );
  xc_match #(.ENTRIES(ENTRIES)) u_inval (
    .valid(valid_q), .tags(tag_q), .sizes(size_q), .addr(flush_addr), .hits(fhit_vec)
  );

  assign flush_any = flush_all || flush_page;
  assign req_ready = (state_q == ST_IDLE) && !flush_any;
  assign accept    = req_valid && req_ready;
  assign walk_done = (state_q == ST_WALK) && walk_rsp_valid;
  assign refill_en = walk_done && !walk_rsp_fault && !flush_any;
  assign hit_cnt   = CNTW'($countones(hit_vec));

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = IDXW'(i);
  end

  assign touch_en  = (accept && hit_cnt == CNTW'(1)) || refill_en;
  assign touch_idx = refill_en ? victim : hit_idx;

  xc_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .valid(valid_q),
    .touch_en(touch_en), .touch_idx(touch_idx), .victim(victim)
  );

  // Entry storage and invalidation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      base_q  <= '0;
      size_q  <= '0;
    end else if (flush_all) begin
      valid_q <= '0;
    end else if (flush_page) begin
      valid_q <= valid_q & ~fhit_vec;
    end else if (refill_en) begin
      valid_q[victim] <= 1'b1;
      tag_q[victim]   <= va_q & page_mask(walk_rsp_size);
      base_q[victim]  <= walk_rsp_pbase & page_mask(walk_rsp_size);
      size_q[victim]  <= walk_rsp_size;
    end
  end

  // Request tracking
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      va_q <= req_vaddr;
      wr_q <= req_write;
      if (hit_cnt == '0) state_q <= ST_WALK;
    end else if (walk_done) begin
      state_q <= ST_IDLE;
    end
  end

  // Response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_fault      <= 1'b0;
      rsp_fault_kind <= FK_WALK;
    end else begin
      rsp_valid      <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_fault_kind <= FK_WALK;
      if (walk_done) begin
        rsp_valid <= 1'b1;
        rsp_fault <= walk_rsp_fault;
        rsp_paddr <= walk_rsp_fault ? '0 : join_addr(walk_rsp_pbase, walk_rsp_size, va_q);
      end else if (accept && hit_cnt != '0) begin
        rsp_valid <= 1'b1;
        if (hit_cnt == CNTW'(1)) begin
          rsp_paddr <= join_addr(base_q[hit_idx], size_q[hit_idx], req_vaddr);
        end else begin
          rsp_fault      <= 1'b1;
          rsp_fault_kind <= req_write ? FK_MULTI_WR : FK_MULTI_RD;
          rsp_paddr      <= '0;
        end
      end
    end
  end

  assign walk_req_valid = (state_q == ST_WALK);
  assign walk_req_vaddr = va_q;

  logic unused_wr;
  assign unused_wr = wr_q;
endmodule

// File: rtl/xc_chk.sv
module xc_chk #(
  parameter int unsigned ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               accept,
  input logic               walk_done,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] fhit_vec,
  input logic [ENTRIES-1:0] valid_q,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic [1:0]         rsp_fault_kind,
  input logic [31:0]        rsp_paddr,
  input logic               walk_req_valid,
  input logic [31:0]        walk_req_vaddr,
  input logic               walk_rsp_valid,
  input logic               walk_rsp_fault,
  input logic               flush_all,
  input logic               flush_page
);
  // R2
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && $countones(hit_vec) == 1 |=> rsp_valid && !rsp_fault && !walk_req_valid);

  // R6
  multi_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && $countones(hit_vec) > 1 |=>
      rsp_valid && rsp_fault && rsp_fault_kind != 2'd0 && rsp_paddr == '0 && !walk_req_valid);

  // R4
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid && !walk_rsp_valid |=> walk_req_valid && $stable(walk_req_vaddr));

  // R4
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(accept) || $past(walk_done));

  // R7
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> valid_q == '0);

  // R8
  flush_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_page && !flush_all |=> (valid_q & $past(fhit_vec)) == '0);

  // R5
  walk_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done && walk_rsp_fault && !flush_all && !flush_page |=> valid_q == $past(valid_q));

  // R9
  flush_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done && flush_page |=> $countones(valid_q) <= $countones($past(valid_q)));
endmodule

bind xlat_cache xc_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .walk_done(walk_done),
  .hit_vec(hit_vec), .fhit_vec(fhit_vec), .valid_q(valid_q),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_fault_kind(rsp_fault_kind),
  .rsp_paddr(rsp_paddr), .walk_req_valid(walk_req_valid), .walk_req_vaddr(walk_req_vaddr),
  .walk_rsp_valid(walk_rsp_valid), .walk_rsp_fault(walk_rsp_fault),
  .flush_all(flush_all), .flush_page(flush_page)
);

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_fault, walk_req_valid;
  logic [31:0] rsp_paddr, walk_req_vaddr;
  logic [1:0] rsp_fault_kind;
  logic walk_rsp_valid = 1'b0, walk_rsp_fault = 1'b0;
  logic [31:0] walk_rsp_pbase = '0;
  logic [1:0] walk_rsp_size = '0;
  logic flush_all = 1'b0, flush_page = 1'b0;
  logic [31:0] flush_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_cache #(.ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_fault_kind(rsp_fault_kind),
    .walk_req_valid(walk_req_valid), .walk_req_vaddr(walk_req_vaddr),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pbase(walk_rsp_pbase),
    .walk_rsp_size(walk_rsp_size), .walk_rsp_fault(walk_rsp_fault),
    .flush_all(flush_all), .flush_page(flush_page), .flush_addr(flush_addr)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  // Reference model: valid, page number, size code, base, last-use stamp
  bit          m_v[N];
  logic [31:0] m_tag[N], m_base[N];
  int          m_sz[N], m_stamp[N];
  int          m_now;

  function automatic int shift_of(input int sz);
    return (sz == 2) ? 20 : ((sz == 1) ? 16 : 12);
  endfunction

  function automatic bit in_page(input logic [31:0] tag, input int sz, input logic [31:0] a);
    int sh = shift_of(sz);
    return (tag >> sh) == (a >> sh);
  endfunction

  function automatic logic [31:0] build(input logic [31:0] b, input int sz, input logic [31:0] va);
    int sh = shift_of(sz);
    logic [31:0] lo = (32'd1 << sh) - 32'd1;
    return ((b >> sh) << sh) | (va & lo);
  endfunction

  function automatic int pick_victim();
    int best = 0;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[best]) best = i;
    return best;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic model_flush_page(input logic [31:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && in_page(m_tag[i], m_sz[i], a)) m_v[i] = 0;
  endtask

  task automatic do_flush_all();
    @(negedge clk);
    flush_all = 1'b1;
    #1 chk(req_ready == 1'b0, "R7 ready low in flush", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    flush_all = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endtask

  task automatic do_flush_page(input logic [31:0] a);
    @(negedge clk);
    flush_page = 1'b1;
    flush_addr = a;
    @(negedge clk);
    flush_page = 1'b0;
    model_flush_page(a);
  endtask

  // One lookup; wfl: 0 none, 1 flush_all, 2 flush_page(fla) with the walker answer
  task automatic lookup(input logic [31:0] va, input bit wr, input logic [31:0] wb,
                        input int wsz, input bit wf, input int wdly, input int wfl,
                        input logic [31:0] fla, input string rq);
    int cnt = 0, idx = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    for (int i = 0; i < N; i++)
      if (m_v[i] && in_page(m_tag[i], m_sz[i], va)) begin cnt++; idx = i; end
    @(negedge clk);
    req_valid = 1'b0;
    if (cnt == 1) begin
      chk(rsp_valid && !rsp_fault && !walk_req_valid, {rq, " R2 hit strobe"},
          {rsp_valid, rsp_fault, walk_req_valid}, 3'b100);
      chk(rsp_paddr == build(m_base[idx], m_sz[idx], va), {rq, " R2 hit paddr"},
          rsp_paddr, build(m_base[idx], m_sz[idx], va));
      m_stamp[idx] = m_now++;
    end else if (cnt > 1) begin
      chk(rsp_valid && rsp_fault && !walk_req_valid && rsp_paddr == 0,
          {rq, " R6 multi fault"}, rsp_paddr, 32'd0);
      chk(rsp_fault_kind == (wr ? 2'd2 : 2'd1), {rq, " R6 kind"},
          {30'd0, rsp_fault_kind}, wr ? 32'd2 : 32'd1);
    end else begin
      chk(walk_req_valid && !rsp_valid && !req_ready && walk_req_vaddr == va,
          {rq, " R4 walk issued"}, walk_req_vaddr, va);
      for (int d = 0; d < wdly; d++) begin
        @(negedge clk);
        chk(walk_req_valid && !req_ready && walk_req_vaddr == va && !rsp_valid,
            {rq, " R4 walk held"}, walk_req_vaddr, va);
      end
      walk_rsp_valid = 1'b1; walk_rsp_pbase = wb; walk_rsp_size = 2'(wsz);
      walk_rsp_fault = wf;
      if (wfl == 1) flush_all = 1'b1;
      if (wfl == 2) begin flush_page = 1'b1; flush_addr = fla; end
      @(negedge clk);
      walk_rsp_valid = 1'b0; walk_rsp_fault = 1'b0; flush_all = 1'b0; flush_page = 1'b0;
      chk(rsp_valid && rsp_fault == wf, {rq, " R4/R9 walk answer"},
          {rsp_valid, rsp_fault}, {1'b1, wf});
      if (wf) chk(rsp_paddr == 0 && rsp_fault_kind == 0, {rq, " R5 fault answer"},
                  rsp_paddr, 32'd0);
      else    chk(rsp_paddr == build(wb, wsz, va), {rq, " R4 walk paddr"},
                  rsp_paddr, build(wb, wsz, va));
      if (wfl == 1) for (int i = 0; i < N; i++) m_v[i] = 0;
      if (wfl == 2) model_flush_page(fla);
      if (!wf && wfl == 0) begin
        int v = pick_victim();
        m_v[v] = 1; m_tag[v] = va; m_sz[v] = wsz; m_base[v] = wb; m_stamp[v] = m_now++;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_stamp[i] = N - i; m_tag[i] = 0; m_base[i] = 0; m_sz[i] = 0; end
    m_now = N + 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
    chk(!rsp_valid && !walk_req_valid, "R1 outputs idle", {30'd0, rsp_valid, walk_req_valid}, 32'd0);

    // R3 sweep: each size code, flip each address bit 12..23
    for (int s = 0; s < 4; s++) begin
      logic [31:0] base_va = 32'h0345_6789;
      do_flush_all();
      lookup(base_va, 0, 32'h9ABC_DEF0, s, 0, s, 0, 0, "R3 fill");
      for (int b = 12; b < 24; b++)
        lookup(base_va ^ (32'd1 << b), b[0], 32'h0, 0, 1, 1, 0, 0, "R3 probe");
      lookup(base_va ^ 32'h0000_0FFF, 0, 0, 0, 1, 0, 0, 0, "R3 offset");
    end

    // R10 replacement sweep
    do_flush_all();
    for (int p = 0; p < N; p++)
      lookup(32'h1000_0000 + p * 32'h1000, 0, 32'h5000_0000 + p * 32'h1_0000, 0, 0, 0, 0, 0, "R10 fill");
    lookup(32'h1000_3000, 0, 0, 0, 1, 0, 0, 0, "R10 touch");
    lookup(32'h1000_0000, 1, 0, 0, 1, 0, 0, 0, "R10 touch");
    lookup(32'h1000_5000, 0, 0, 0, 1, 0, 0, 0, "R10 touch");
    for (int p = N; p < N + 3; p++)
      lookup(32'h1000_0000 + p * 32'h1000, 0, 32'h6000_0000 + p * 32'h1_0000, 0, 0, 2, 0, 0, "R10 evict");
    for (int p = 0; p < N + 3; p++)
      lookup(32'h1000_0000 + p * 32'h1000, 0, 0, 0, 1, 0, 0, 0, "R10 probe");

    // R6 multi-hit from overlapping sizes
    do_flush_all();
    lookup(32'h0010_3000, 0, 32'h7700_0000, 0, 0, 0, 0, 0, "R6 small");
    lookup(32'h0010_5000, 0, 32'h8800_0000, 2, 0, 1, 0, 0, "R6 section");
    lookup(32'h0010_3ABC, 0, 0, 0, 1, 0, 0, 0, "R6 read");
    lookup(32'h0010_3ABC, 1, 0, 0, 1, 0, 0, 0, "R6 write");

    // R8 page flush removes only the covering section
    do_flush_page(32'h0012_0000);
    lookup(32'h0010_3004, 0, 0, 0, 1, 0, 0, 0, "R8 kept");
    lookup(32'h0010_5004, 0, 0, 0, 1, 0, 0, 0, "R8 removed");
    do_flush_page(32'h0010_3000);
    lookup(32'h0010_3004, 1, 0, 0, 1, 0, 0, 0, "R8 gone");

    // R5 walker fault does not allocate
    lookup(32'h2222_0000, 0, 32'h1234_5000, 1, 1, 2, 0, 0, "R5 fault");
    lookup(32'h2222_0000, 0, 32'h1234_5000, 1, 1, 0, 0, 0, "R5 refault");

    // R9 flush alongside refill
    lookup(32'h3333_0000, 0, 32'hA000_0000, 1, 0, 1, 1, 0, "R9 flush_all");
    lookup(32'h3333_0000, 0, 0, 0, 1, 0, 0, 0, "R9 not kept");
    lookup(32'h4444_0000, 0, 32'hB000_0000, 0, 0, 0, 2, 32'h7000_0000, "R9 flush_page");
    lookup(32'h4444_0000, 0, 0, 0, 1, 0, 0, 0, "R9 not kept");

    // R7 flush_all clears everything
    lookup(32'h5555_1000, 0, 32'hC000_0000, 0, 0, 0, 0, 0, "R7 fill");
    lookup(32'h5555_1000, 0, 0, 0, 1, 0, 0, 0, "R7 hit");
    do_flush_all();
    lookup(32'h5555_1000, 0, 0, 0, 1, 0, 0, 0, "R7 cleared");

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule